// File: doc/BRIEF.md
# I2C Interrupt Source Prioritizer

This block gathers the event indications of an I2C controller into one status word, gates them with a software-set enable mask, and drives a single interrupt request. Single-cycle pulses mark one-off events (arbitration lost, no acknowledge, access ready, stop condition seen, addressed as a target). Level inputs carry the receive-data-available and transmit-space-available conditions. Two further levels, receive shift full and bus busy, are shown in the status word for software only.

A handler reads a vector register to learn which enabled source needs service. The register returns a small code for the winning source, and that read also clears the source's sticky flag. Repeated reads therefore hand out pending events one at a time, and the read that returns zero shows nothing enabled is left. The lowest code has the highest priority. A register read/write port reaches three registers: status (address 0), enable mask (address 1) and vector (address 2). Reads are combinational. Writes, and the clearing side effect of a vector read, take effect at the clock edge on which the strobe is high.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset the status, mask and vector registers read 0 and `irq_o` is 0.
- R2: An event pulse sets its sticky status bit and the bit stays set: bit 0 arbitration lost, bit 1 no acknowledge, bit 2 access ready, bit 5 stop seen, bit 6 addressed as target.
- R3: Writing the status register clears every sticky bit whose write-data bit is 1 and leaves the bits written 0 unchanged. An event arriving in the same cycle as its clear wins, and the bit stays set.
- R4: Status bit 3 follows `rx_data_rdy`, bit 4 follows `tx_space_rdy`, bit 11 follows `rx_shift_full` and bit 12 follows `bus_busy`. Writing 1 to any of these bits has no effect.
- R5: Mask bits 0..6 enable the sources in status-bit order and can be written and read back. Mask bits 7..15 always read 0.
- R6: The vector reads (index+1) of the lowest-indexed pending enabled source: 1 arbitration lost, 2 no acknowledge, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop seen, 7 addressed as target. It reads 0 when no enabled source is pending.
- R7: A vector read clears the sticky flag of the source it reports. The receive-ready and transmit-ready sources stay pending while their input level is high.
- R8: Repeated vector reads return the pending enabled sticky sources one at a time in priority order and then return 0.
- R9: `irq_o` is a register. On each clock edge it takes the OR of (pending AND mask) as it stood before that edge.
- R10: A pending source whose mask bit is 0 still shows in status, but it is never reported by the vector and never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_nack | input | 1 | Pulse: no acknowledge received |
| ev_acc_rdy | input | 1 | Pulse: access ready |
| ev_stop_det | input | 1 | Pulse: stop condition seen |
| ev_addr_tgt | input | 1 | Pulse: addressed as target |
| rx_data_rdy | input | 1 | Level: received data waiting |
| tx_space_rdy | input | 1 | Level: transmit data wanted |
| rx_shift_full | input | 1 | Level: receive shifter full (status only) |
| bus_busy | input | 1 | Level: bus busy (status only) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 vector |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a clear and a new event that hit the same flag on the same clock edge. Here the order in which the bench drives the strobes decides what is observed. The bench drives a no-acknowledge pulse and a write-one-to-clear of that bit on the same clock edge, then reads status back. Draining also needs care: several sources with mixed masks are loaded, and the vector is read until zero while a model in the bench retires the expected lowest enabled source after each read. The level sources are checked to survive vector reads and clear writes while held high.

// File: rtl/i2c_irqv_pkg.sv
// Shared constants for the I2C interrupt source prioritizer.
// Assumes seven sources whose index+1 is their vector code.
package i2c_irqv_pkg;
    localparam int unsigned SRC_N      = 7;
    localparam int unsigned CODE_W     = $clog2(SRC_N + 1);
    localparam int unsigned REG_W      = 16;
    localparam int unsigned ADDR_W     = 2;

    localparam int unsigned SRC_ARB    = 0;
    localparam int unsigned SRC_NACK   = 1;
    localparam int unsigned SRC_ACC    = 2;
    localparam int unsigned SRC_RX     = 3;
    localparam int unsigned SRC_TX     = 4;
    localparam int unsigned SRC_STOP   = 5;
    localparam int unsigned SRC_TGT    = 6;

    // Sources that mirror a level instead of holding a sticky flag
    localparam logic [SRC_N-1:0] LEVEL_SRC = 7'b0011000;

    localparam int unsigned RSFULL_BIT = 11;
    localparam int unsigned BUSY_BIT   = 12;

    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_VEC  = 2'd2;
endpackage

// File: rtl/i2c_irqv_flags.sv
// Pending-flag bank. Each source is a sticky flag (set by pulse, cleared
// by write-one-to-clear or by a vector read, set winning) or a mirror of
// a level input, chosen per bit by LEVEL_MASK.
// Assumes clear strobes are already qualified by the caller.
module i2c_irqv_flags #(
    parameter int unsigned N = 7,
    parameter logic [N-1:0] LEVEL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] w1c_i,
    input  logic [N-1:0] rdclr_i,
    output logic [N-1:0] pend_o
);
    // Inputs meaningless for a given flag kind are folded here
    logic unused_kind_bits;
    assign unused_kind_bits = ^{set_i & LEVEL_MASK, w1c_i & LEVEL_MASK,
                                rdclr_i & LEVEL_MASK, lvl_i & ~LEVEL_MASK};

    for (genvar g = 0; g < N; g++) begin : g_flag
        if (LEVEL_MASK[g]) begin : g_level
            // Level source: pending exactly while its condition holds
            assign pend_o[g] = lvl_i[g];
        end else begin : g_sticky
            logic flag_q;
            // Sticky source: new event beats a clear in the same cycle
            always_ff @(posedge clk) begin
                if (!rst_n)                       flag_q <= 1'b0;
                else if (set_i[g])                flag_q <= 1'b1;
                else if (w1c_i[g] || rdclr_i[g])  flag_q <= 1'b0;
            end
            assign pend_o[g] = flag_q;
        end
    end
endmodule

// File: rtl/i2c_irqv_prio.sv
// Fixed-priority encoder: lowest index wins. Gives a one-hot grant and
// the code index+1, or zero code and no grant when nothing requests.
module i2c_irqv_prio #(
    parameter int unsigned N  = 7,
    parameter int unsigned CW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [CW-1:0] code_o
);
    // Scan from the weakest source so the strongest is assigned last
    always_comb begin
        grant_o = '0;
        code_o  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                code_o     = CW'(i + 1);
            end
        end
    end
endmodule

// File: rtl/i2c_irq_vector.sv
// Top of the I2C interrupt source prioritizer: register port (status,
// mask, vector), pending-flag bank, priority encoder and registered IRQ.
// Assumes reg_rd/reg_wr are single-cycle strobes from a register bus.
module i2c_irq_vector
    import i2c_irqv_pkg::*;
#(
    parameter int unsigned DATA_W = REG_W,
    parameter int unsigned AW     = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_arb_lost,
    input  logic              ev_nack,
    input  logic              ev_acc_rdy,
    input  logic              ev_stop_det,
    input  logic              ev_addr_tgt,
    input  logic              rx_data_rdy,
    input  logic              tx_space_rdy,
    input  logic              rx_shift_full,
    input  logic              bus_busy,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    logic [SRC_N-1:0]  ev_vec, lvl_vec, w1c_vec, rdclr_vec;
    logic [SRC_N-1:0]  pend, mask_q, req, grant;
    logic [CODE_W-1:0] vec_code;
    logic              wr_stat, wr_mask, rd_vec, irq_q;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:SRC_N];

    // Gather source inputs into index order (index+1 is the vector code)
    always_comb begin
        ev_vec            = '0;
        lvl_vec           = '0;
        ev_vec[SRC_ARB]   = ev_arb_lost;
        ev_vec[SRC_NACK]  = ev_nack;
        ev_vec[SRC_ACC]   = ev_acc_rdy;
        ev_vec[SRC_STOP]  = ev_stop_det;
        ev_vec[SRC_TGT]   = ev_addr_tgt;
        lvl_vec[SRC_RX]   = rx_data_rdy;
        lvl_vec[SRC_TX]   = tx_space_rdy;
    end

    assign wr_stat   = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_mask   = reg_wr && (reg_addr == ADDR_MASK);
    assign rd_vec    = reg_rd && (reg_addr == ADDR_VEC);
    assign w1c_vec   = wr_stat ? reg_wdata[SRC_N-1:0] : '0;
    assign rdclr_vec = rd_vec ? grant : '0;

    i2c_irqv_flags #(.N(SRC_N), .LEVEL_MASK(LEVEL_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ev_vec),
        .lvl_i   (lvl_vec),
        .w1c_i   (w1c_vec),
        .rdclr_i (rdclr_vec),
        .pend_o  (pend)
    );

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= reg_wdata[SRC_N-1:0];
    end

    assign req = pend & mask_q;

    i2c_irqv_prio #(.N(SRC_N), .CW(CODE_W)) u_prio (
        .req_i   (req),
        .grant_o (grant),
        .code_o  (vec_code)
    );

    // Registered interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |req;
    end
    assign irq_o = irq_q;

    // Read data multiplexer
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_STAT: begin
                reg_rdata[SRC_N-1:0] = pend;
                reg_rdata[RSFULL_BIT] = rx_shift_full;
                reg_rdata[BUSY_BIT]   = bus_busy;
            end
            ADDR_MASK: reg_rdata[SRC_N-1:0]  = mask_q;
            ADDR_VEC:  reg_rdata[CODE_W-1:0] = vec_code;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_irqv_chk.sv
// Property checker for i2c_irq_vector, bound into every instance.
// Assumes it sees the pending vector, mask and grant of the top.
module i2c_irqv_chk
    import i2c_irqv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_rd,
    input logic             reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic             wdata_nack,
    input logic [REG_W-1:SRC_N] rdata_hi,
    input logic             ev_arb_lost,
    input logic             ev_nack,
    input logic [SRC_N-1:0] pend,
    input logic [SRC_N-1:0] mask_q,
    input logic [SRC_N-1:0] grant,
    input logic             irq_o
);
    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(pend & mask_q)));

    // R7
    arb_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_VEC && grant[SRC_ARB] && !ev_arb_lost)
        |=> !pend[SRC_ARB]);

    // R3
    nack_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STAT && wdata_nack && !ev_nack)
        |=> !pend[SRC_NACK]);

    // R3
    nack_setwins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> pend[SRC_NACK]);

    // R10
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq_o);

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5
    mask_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_MASK) |-> rdata_hi == '0);
endmodule

bind i2c_irq_vector i2c_irqv_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .wdata_nack  (reg_wdata[1]),
    .rdata_hi    (reg_rdata[15:7]),
    .ev_arb_lost (ev_arb_lost),
    .ev_nack     (ev_nack),
    .pend        (pend),
    .mask_q      (mask_q),
    .grant       (grant),
    .irq_o       (irq_o)
);

// File: tb/sim_i2c_irq_vector.sv
module sim_i2c_irq_vector;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_STAT = 2'd0, A_MASK = 2'd1, A_VEC = 2'd2;
    // Entry: {mask[6:0], sticky events[6:0], expected first vector code}
    localparam logic [16:0] TBL [8] = '{
        {7'h7F, 7'b0000001, 3'd1},
        {7'h7F, 7'b1100110, 3'd2},
        {7'h7F, 7'b1100000, 3'd6},
        {7'h5F, 7'b1100000, 3'd7},
        {7'h00, 7'b1100111, 3'd0},
        {7'h7E, 7'b0000011, 3'd2},
        {7'h7F, 7'b1000000, 3'd7},
        {7'h04, 7'b0100100, 3'd3}
    };

    logic clk = 0, rst_n = 0;
    logic ev_arb = 0, ev_nack = 0, ev_acc = 0, ev_stop = 0, ev_tgt = 0;
    logic rx_rdy = 0, tx_rdy = 0, rs_full = 0, busy = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [1:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic irq;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_irq_vector u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_arb_lost(ev_arb), .ev_nack(ev_nack), .ev_acc_rdy(ev_acc),
        .ev_stop_det(ev_stop), .ev_addr_tgt(ev_tgt),
        .rx_data_rdy(rx_rdy), .tx_space_rdy(tx_rdy),
        .rx_shift_full(rs_full), .bus_busy(busy),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic pulse(input logic [6:0] e);
        @(negedge clk);
        ev_arb = e[0]; ev_nack = e[1]; ev_acc = e[2]; ev_stop = e[5]; ev_tgt = e[6];
        @(negedge clk);
        ev_arb = 0; ev_nack = 0; ev_acc = 0; ev_stop = 0; ev_tgt = 0;
    endtask

    function automatic logic [2:0] lowest(input logic [6:0] v);
        for (int i = 6; i >= 0; i--) if (v[i]) lowest = 3'(i + 1);
        if (v == 0) lowest = 0;
    endfunction

    initial begin
        logic [15:0] v;
        logic [6:0]  model, msk, ev;
        logic [2:0]  exp;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state
        check("R1 irq", {15'b0, irq}, 0);
        rd_reg(A_STAT, v); check("R1 status", v, 0);
        rd_reg(A_MASK, v); check("R1 mask", v, 0);
        rd_reg(A_VEC, v);  check("R1 vector", v, 0);

        // Table walk: R2, R6, R8, R9, R10
        for (int k = 0; k < 8; k++) begin
            msk = TBL[k][16:10]; ev = TBL[k][9:3];
            wr_reg(A_STAT, 16'hFFFF);
            wr_reg(A_MASK, {9'b0, msk});
            pulse(ev);
            rd_reg(A_STAT, v); check("R2/R10 status", v, {9'b0, ev});
            check("R9 irq raised", {15'b0, irq}, {15'b0, |(ev & msk)});
            model = ev & msk;
            for (int r = 0; r < 8; r++) begin
                exp = lowest(model);
                rd_reg(A_VEC, v);
                if (r == 0) check("R6 first code", v, {13'b0, TBL[k][2:0]});
                else        check("R8 drain", v, {13'b0, exp});
                if (exp == 0) break;
                model[exp-1] = 1'b0;
            end
            check("R9 irq after drain", {15'b0, irq}, 0);
            rd_reg(A_STAT, v); check("R10 masked left", v, {9'b0, ev & ~msk});
        end

        // R3: write-one-to-clear and set-wins
        wr_reg(A_STAT, 16'hFFFF); wr_reg(A_MASK, 16'h0000);
        pulse(7'b0000010);
        wr_reg(A_STAT, 16'hFFFD);
        rd_reg(A_STAT, v); check("R3 zero keeps", v, 16'h0002);
        wr_reg(A_STAT, 16'h0002);
        rd_reg(A_STAT, v); check("R3 one clears", v, 16'h0000);
        @(negedge clk); ev_nack = 1; reg_wr = 1; reg_addr = A_STAT; reg_wdata = 16'h0002;
        @(negedge clk); ev_nack = 0; reg_wr = 0;
        rd_reg(A_STAT, v); check("R3 set wins", v, 16'h0002);
        wr_reg(A_STAT, 16'hFFFF);

        // R4: level status bits
        @(negedge clk); rx_rdy = 1; busy = 1; rs_full = 1;
        wr_reg(A_STAT, 16'hFFFF);
        rd_reg(A_STAT, v); check("R4 levels", v, 16'h1808);

        // R7: level source survives vector reads; priority among levels
        wr_reg(A_MASK, 16'h001C);
        rd_reg(A_VEC, v); check("R7 rx code", v, 16'd4);
        rd_reg(A_VEC, v); check("R7 rx stays", v, 16'd4);
        @(negedge clk); tx_rdy = 1;
        rd_reg(A_VEC, v); check("R6 rx over tx", v, 16'd4);
        @(negedge clk); rx_rdy = 0;
        pulse(7'b0000100);
        rd_reg(A_VEC, v); check("R6 acc over tx", v, 16'd3);
        rd_reg(A_VEC, v); check("R7 acc cleared tx", v, 16'd5);
        @(negedge clk); tx_rdy = 0; busy = 0; rs_full = 0;
        rd_reg(A_VEC, v); check("R8 empty", v, 16'd0);

        // R5: mask width
        wr_reg(A_MASK, 16'hFFFF);
        rd_reg(A_MASK, v); check("R5 mask readback", v, 16'h007F);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule